// File: doc/BRIEF.md
# DDR SDRAM Open-Page Read Sequencer

This block turns a stream of word-addressed read requests into the command sequence for one multi-bank SDRAM device. Each request arrives on a valid/ready handshake with a flat word address. The block splits the address into row, bank and column. It then issues only the commands the target bank needs: a bare READ when the requested row is already open, ACTIVATE then READ when the bank is closed, and PRECHARGE, ACTIVATE, READ when a different row is open. Rows stay open after a read, so later accesses to the same page are cheap.

Each bank has its own timers for the activate-to-read, activate-to-precharge and activate-to-activate minimums. The shared data bus is tracked on its own, so the timers of one bank never hold back a command to another bank. A bank can therefore be precharged and activated while a burst from a different bank is still on the bus. Read data is produced by a behavioural pattern generator, two beats per clock, so the command timing can be checked end to end.

Top module: `ddr_page_seq`

## Requirements
- R1: The request address decodes as row = addr[26:13], bank = addr[12:11] and column = addr[10:0]. Every command carries the held bank on `cmd_bank`; ACTIVATE and READ also carry the row on `cmd_row`, and READ carries the column on `cmd_col`. Command codes on `cmd_op`: 0 idle, 1 ACTIVATE, 2 READ, 3 PRECHARGE.
- R2: After reset `cmd_op` is 0, `req_ready` is 1 and `rd_valid` is 0, and every bank is closed, so the first request to any bank produces ACTIVATE then READ.
- R3: A request whose row is open in its bank produces one READ and no other command. With the bus free, the READ appears 2 cycles after the accept cycle.
- R4: A request to a closed bank produces ACTIVATE then READ. With the timers expired, the ACTIVATE appears 2 cycles after acceptance.
- R5: A request to a bank with another row open produces PRECHARGE, ACTIVATE, READ in that order, with ACTIVATE one cycle after PRECHARGE when tRC allows.
- R6: A READ comes at least T_RCD (default 3) cycles after the ACTIVATE of its bank, and exactly T_RCD after it when the bus is free.
- R7: A PRECHARGE comes at least T_RAS (default 8) cycles after the ACTIVATE of its bank, and exactly T_RAS after it when a miss follows an activate at once.
- R8: Two ACTIVATEs to one bank are at least T_RC (default 11) cycles apart, and exactly T_RC apart for an immediate miss after an activate.
- R9: The first data cycle comes T_CL (default 3) cycles after a READ. A burst of 8 beats fills 4 consecutive cycles with `rd_valid` high. In cycle k (0..3), `rd_rise` = col[7:0]+2k and `rd_fall` = col[7:0]+2k+1, both modulo 256. `rd_last` is high only in cycle 3.
- R10: Two READs are at least 4 cycles apart, so bursts never overlap, and back-to-back page hits issue READs exactly 4 cycles apart.
- R11: A PRECHARGE or ACTIVATE for one bank is not held back by a burst of another bank, so an ACTIVATE can coincide with `rd_valid`.
- R12: Requests are served in arrival order. `req_ready` is low from the cycle after an accept until the cycle in which that request's READ appears, and is high again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | 27 | Word address {row, bank, column} |
| cmd_op | output | 2 | Command code: 0 idle, 1 activate, 2 read, 3 precharge |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | 14 | Row of the command |
| cmd_col | output | 11 | Column of a read |
| rd_valid | output | 1 | Data cycle of a burst |
| rd_rise | output | 8 | Beat on the rising edge |
| rd_fall | output | 8 | Beat on the falling edge |
| rd_last | output | 1 | Final data cycle of a burst |

## Verification
Every cycle, the assertions check the minimum spacings: activate to read, activate to precharge, activate to activate and read to read. They also check that an activate only targets a closed bank, a precharge only an open one, and a read only the open row. Every cycle they also check that ready drops after an accept. The order and choice of commands for hit, closed and miss cases, the exact latencies, the data pattern and the overlap of activation with a burst of another bank are shown only by the bench scenarios. The bench checks them against a model of open rows and timing built from the request stream.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_PRE = 2'd3
  } ddr_op_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_RD
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int TW    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  output logic rd_ok,
  output logic pre_ok,
  output logic act_ok
);

  logic [TW-1:0] rcd_left, ras_left, rc_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcd_left <= '0;
      ras_left <= '0;
      rc_left  <= '0;
    end else if (act) begin
      rcd_left <= TW'(T_RCD - 1);
      ras_left <= TW'(T_RAS - 1);
      rc_left  <= TW'(T_RC - 1);
    end else begin
      if (rcd_left != '0) rcd_left <= rcd_left - 1'b1;
      if (ras_left != '0) ras_left <= ras_left - 1'b1;
      if (rc_left  != '0) rc_left  <= rc_left - 1'b1;
    end
  end

  assign rd_ok  = (rcd_left == '0);
  assign pre_ok = (ras_left == '0);
  assign act_ok = (rc_left == '0);

endmodule

// File: rtl/ddr_row_table.sv
module ddr_row_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              clr,
  input  logic [BANK_W-1:0] wbank,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [BANK_W-1:0] rbank,
  output logic              open_o,
  output logic [ROW_W-1:0]  row_o
);

  localparam int BANKS = 1 << BANK_W;

  logic              open_q [BANKS];
  logic [ROW_W-1:0]  row_q  [BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++) open_q[b] <= 1'b0;
    end else if (set) begin
      open_q[wbank] <= 1'b1;
    end else if (clr) begin
      open_q[wbank] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set) row_q[wbank] <= wrow;
  end

  assign open_o = open_q[rbank];
  assign row_o  = row_q[rbank];

endmodule

// File: rtl/ddr_burst_gen.sv
module ddr_burst_gen #(
  parameter int DQ_W      = 8,
  parameter int T_CL      = 3,
  parameter int BURST_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_cmd,
  input  logic [DQ_W-1:0] rd_col,
  output logic            valid,
  output logic [DQ_W-1:0] rise,
  output logic [DQ_W-1:0] fall,
  output logic            last
);

  localparam int PIPE = T_CL - 1;
  localparam int BCW  = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1;

  logic            vpipe [PIPE];
  logic [DQ_W-1:0] cpipe [PIPE];
  logic            start;
  logic [DQ_W-1:0] start_col;
  logic [BCW-1:0]  bc, bc_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PIPE; i++) vpipe[i] <= 1'b0;
    end else begin
      vpipe[0] <= rd_cmd;
      for (int i = 1; i < PIPE; i++) vpipe[i] <= vpipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    cpipe[0] <= rd_col;
    for (int i = 1; i < PIPE; i++) cpipe[i] <= cpipe[i-1];
  end

  assign start     = vpipe[PIPE-1];
  assign start_col = cpipe[PIPE-1];
  assign bc_nxt    = bc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      last  <= 1'b0;
      bc    <= '0;
      rise  <= '0;
      fall  <= '0;
    end else if (start) begin
      valid <= 1'b1;
      bc    <= '0;
      rise  <= start_col;
      fall  <= start_col + 1'b1;
      last  <= (BURST_CYC == 1);
    end else if (valid && !last) begin
      bc    <= bc_nxt;
      rise  <= rise + DQ_W'(2);
      fall  <= fall + DQ_W'(2);
      last  <= (bc_nxt == BCW'(BURST_CYC - 1));
    end else begin
      valid <= 1'b0;
      last  <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr_page_seq.sv
module ddr_page_seq
  import ddr_seq_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 8,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  parameter int T_CL      = 3,
  parameter int T_RAS     = 8,
  parameter int T_RC      = 11
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ROW_W+BANK_W+COL_W-1:0]  req_addr,
  output logic [1:0]                     cmd_op,
  output logic [BANK_W-1:0]              cmd_bank,
  output logic [ROW_W-1:0]               cmd_row,
  output logic [COL_W-1:0]               cmd_col,
  output logic                           rd_valid,
  output logic [DQ_W-1:0]                rd_rise,
  output logic [DQ_W-1:0]                rd_fall,
  output logic                           rd_last
);

  localparam int BANKS     = 1 << BANK_W;
  localparam int ADDR_W    = ROW_W + BANK_W + COL_W;
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int GAP_W     = $clog2(BURST_CYC + 1);
  localparam int TW        = $clog2(max3(T_RCD, T_RAS, T_RC) + 1);

  seq_state_t        state;
  ddr_op_t           op_q;
  logic [ROW_W-1:0]  in_row, hold_row, tbl_row;
  logic [BANK_W-1:0] in_bank, hold_bank;
  logic [COL_W-1:0]  in_col, hold_col;
  logic              tbl_open, accept;
  logic              issue_pre, issue_act, issue_rd;
  logic [BANKS-1:0]  rd_ok, pre_ok, act_ok, act_vec;
  logic [GAP_W-1:0]  gap_left;

  assign in_row  = req_addr[ADDR_W-1 -: ROW_W];
  assign in_bank = req_addr[COL_W +: BANK_W];
  assign in_col  = req_addr[COL_W-1:0];

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign act_vec[b] = issue_act && (hold_bank == BANK_W'(b));
      ddr_bank_timer #(
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .TW(TW)
      ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .act   (act_vec[b]),
        .rd_ok (rd_ok[b]),
        .pre_ok(pre_ok[b]),
        .act_ok(act_ok[b])
      );
    end
  endgenerate

  ddr_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk   (clk),
    .rst   (rst),
    .set   (issue_act),
    .clr   (issue_pre),
    .wbank (hold_bank),
    .wrow  (hold_row),
    .rbank (in_bank),
    .open_o(tbl_open),
    .row_o (tbl_row)
  );

  always_comb begin
    issue_pre = 1'b0;
    issue_act = 1'b0;
    issue_rd  = 1'b0;
    case (state)
      ST_PRE:  issue_pre = pre_ok[hold_bank];
      ST_ACT:  issue_act = act_ok[hold_bank];
      ST_RD:   issue_rd  = rd_ok[hold_bank] && (gap_left == '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (tbl_open && tbl_row == in_row) state <= ST_RD;
          else if (tbl_open)                 state <= ST_PRE;
          else                               state <= ST_ACT;
        end
        ST_PRE:  if (issue_pre) state <= ST_ACT;
        ST_ACT:  if (issue_act) state <= ST_RD;
        ST_RD:   if (issue_rd)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hold_row  <= in_row;
      hold_bank <= in_bank;
      hold_col  <= in_col;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_left <= '0;
    end else if (issue_rd) begin
      gap_left <= GAP_W'(BURST_CYC - 1);
    end else if (gap_left != '0) begin
      gap_left <= gap_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_NOP;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
    end else begin
      if (issue_pre)      op_q <= OP_PRE;
      else if (issue_act) op_q <= OP_ACT;
      else if (issue_rd)  op_q <= OP_RD;
      else                op_q <= OP_NOP;
      if (issue_pre || issue_act || issue_rd) begin
        cmd_bank <= hold_bank;
        cmd_row  <= hold_row;
        cmd_col  <= hold_col;
      end
    end
  end

  assign cmd_op = op_q;

  ddr_burst_gen #(.DQ_W(DQ_W), .T_CL(T_CL), .BURST_CYC(BURST_CYC)) u_burst (
    .clk   (clk),
    .rst   (rst),
    .rd_cmd(op_q == OP_RD),
    .rd_col(cmd_col[DQ_W-1:0]),
    .valid (rd_valid),
    .rise  (rd_rise),
    .fall  (rd_fall),
    .last  (rd_last)
  );

endmodule

// File: rtl/ddr_page_seq_chk.sv
module ddr_page_seq_chk #(
  parameter int ROW_W     = 14,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RC      = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic              rd_valid,
  input logic              rd_last
);

  localparam int BANKS = 1 << BANK_W;
  localparam int BURST_CYC = BURST_LEN / 2;

  logic [7:0]       since_act [BANKS];
  logic [7:0]       since_rd;
  logic             opn  [BANKS];
  logic [ROW_W-1:0] orow [BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++) begin
        since_act[b] <= 8'hFF;
        opn[b]       <= 1'b0;
        orow[b]      <= '0;
      end
      since_rd <= 8'hFF;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (cmd_op == 2'd1 && cmd_bank == BANK_W'(b)) begin
          since_act[b] <= 8'd1;
          opn[b]       <= 1'b1;
          orow[b]      <= cmd_row;
        end else begin
          if (since_act[b] != 8'hFF) since_act[b] <= since_act[b] + 8'd1;
          if (cmd_op == 2'd3 && cmd_bank == BANK_W'(b)) opn[b] <= 1'b0;
        end
      end
      if (cmd_op == 2'd2)        since_rd <= 8'd1;
      else if (since_rd != 8'hFF) since_rd <= since_rd + 8'd1;
    end
  end

  p_rd_after_rcd_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd2 |-> since_act[cmd_bank] >= 8'(T_RCD));

  p_pre_after_ras_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd3 |-> since_act[cmd_bank] >= 8'(T_RAS));

  p_act_after_rc_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd1 |-> since_act[cmd_bank] >= 8'(T_RC));

  p_bus_gap_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd2 |-> since_rd >= 8'(BURST_CYC));

  p_act_closed_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd1 |-> !opn[cmd_bank]);

  p_pre_open_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd3 |-> opn[cmd_bank]);

  p_rd_open_row_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_op == 2'd2 |-> (opn[cmd_bank] && orow[cmd_bank] == cmd_row));

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_last_in_burst_r9: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

endmodule

bind ddr_page_seq ddr_page_seq_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN),
  .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .cmd_op   (cmd_op),
  .cmd_bank (cmd_bank),
  .cmd_row  (cmd_row),
  .rd_valid (rd_valid),
  .rd_last  (rd_last)
);

// File: tb/ddr_page_seq_tb.sv
module ddr_page_seq_tb;

  localparam int T_RCD = 3;
  localparam int T_CL  = 3;
  localparam int T_RAS = 8;
  localparam int T_RC  = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [26:0] req_addr = '0;
  logic [1:0]  cmd_op;
  logic [1:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [10:0] cmd_col;
  logic        rd_valid, rd_last;
  logic [7:0]  rd_rise, rd_fall;

  always #4 clk = ~clk;

  ddr_page_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_valid(rd_valid),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .rd_last(rd_last)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // request model: kind 0 hit, 1 closed, 2 miss
  int q_bank [64], q_row [64], q_col [64], q_kind [64], q_acc [64];
  int q_wr = 0, q_rd = 0, step = 0;
  bit m_open [4];
  int m_row  [4];

  int last_act [4];
  int last_rd = -1000;
  int rd_lat = 0, rd_gap = 0, pre_gap = 0, act_gap = 0, ovl_cnt = 0;
  int b_start [8], b_col [8];
  int b_wr = 0, b_rd = 0;
  bit acc_prev = 0;

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 0; m_row[b] = 0; last_act[b] = -1000;
    end
  end

  function automatic int exp_op(input int kind, input int s);
    if (kind == 0) return 2;
    if (kind == 1) return (s == 0) ? 1 : 2;
    return (s == 0) ? 3 : ((s == 1) ? 1 : 2);
  endfunction

  function automatic string kind_req(input int kind);
    if (kind == 0) return "R3";
    if (kind == 1) return "R4";
    return "R5";
  endfunction

  task automatic send(input int b, input int row, input int col);
    int kind;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = {row[13:0], b[1:0], col[10:0]};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (m_open[b] && m_row[b] == row) kind = 0;
    else if (m_open[b]) kind = 2;
    else kind = 1;
    m_open[b] = 1; m_row[b] = row;
    q_bank[q_wr % 64] = b; q_row[q_wr % 64] = row; q_col[q_wr % 64] = col;
    q_kind[q_wr % 64] = kind; q_acc[q_wr % 64] = cyc;
    q_wr++;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_rd != q_wr || b_rd != b_wr) @(negedge clk);
    repeat (T_RC + 4) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_prev) chk(!req_ready, "R12", "ready after accept", req_ready, 0);
      acc_prev = req_valid && req_ready;

      if (cmd_op != 2'd0) begin
        int hb, kind, eop;
        hb = q_rd % 64;
        if (q_rd == q_wr) begin
          chk(0, "R12", "command with no request", cmd_op, 0);
        end else begin
          kind = q_kind[hb];
          eop  = exp_op(kind, step);
          chk(cmd_op == eop[1:0], kind_req(kind), "command order", cmd_op, eop);
          chk(cmd_bank == q_bank[hb][1:0], "R1", "command bank", cmd_bank, q_bank[hb]);
          if (cmd_op != 2'd3)
            chk(cmd_row == q_row[hb][13:0], "R1", "command row", cmd_row, q_row[hb]);
          if (cmd_op == 2'd2)
            chk(cmd_col == q_col[hb][10:0], "R1", "read column", cmd_col, q_col[hb]);
        end
        case (cmd_op)
          2'd1: begin
            act_gap = cyc - last_act[cmd_bank];
            chk(act_gap >= T_RC, "R8", "act to act", act_gap, T_RC);
            last_act[cmd_bank] = cyc;
            if (rd_valid) ovl_cnt++;
            step++;
          end
          2'd3: begin
            pre_gap = cyc - last_act[cmd_bank];
            chk(pre_gap >= T_RAS, "R7", "act to pre", pre_gap, T_RAS);
            step++;
          end
          2'd2: begin
            chk(cyc - last_act[cmd_bank] >= T_RCD, "R6", "act to read",
                cyc - last_act[cmd_bank], T_RCD);
            rd_gap = cyc - last_rd;
            chk(rd_gap >= 4, "R10", "read spacing", rd_gap, 4);
            last_rd = cyc;
            rd_lat = cyc - q_acc[hb];
            chk(req_ready, "R12", "ready with read", req_ready, 1);
            b_start[b_wr % 8] = cyc + T_CL;
            b_col[b_wr % 8]   = q_col[hb];
            b_wr++;
            q_rd++;
            step = 0;
          end
          default: ;
        endcase
      end

      if (b_rd != b_wr && cyc >= b_start[b_rd % 8]) begin
        int k, er, ef;
        bit el;
        k  = cyc - b_start[b_rd % 8];
        er = (b_col[b_rd % 8] + 2 * k) % 256;
        ef = (er + 1) % 256;
        el = (k == 3);
        chk(rd_valid && rd_rise == er[7:0] && rd_fall == ef[7:0] && rd_last == el,
            "R9", "burst beat rise", rd_rise, er);
        if (k >= 3) b_rd++;
      end else if (rd_valid) begin
        chk(0, "R9", "unexpected data", 1, 0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(cmd_op == 2'd0, "R2", "reset command", cmd_op, 0);
    chk(req_ready == 1'b1, "R2", "reset ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R2", "reset data valid", rd_valid, 0);

    send(0, 7, 16);
    drain();
    chk(rd_lat == 2 + T_RCD, "R4", "closed bank read latency", rd_lat, 2 + T_RCD);
    chk(rd_lat == 2 + T_RCD, "R6", "read after activate", rd_lat - 2, T_RCD);

    send(0, 7, 32);
    drain();
    chk(rd_lat == 2, "R3", "hit read latency", rd_lat, 2);

    send(0, 9, 40);
    drain();
    chk(rd_lat == 3 + T_RCD, "R5", "miss read latency", rd_lat, 3 + T_RCD);

    for (int i = 0; i < 4; i++) send(0, 9, 100 + 8 * i);
    drain();
    chk(rd_gap == 4, "R10", "back-to-back hit spacing", rd_gap, 4);

    send(2, 1, 0);
    send(2, 2, 8);
    drain();
    chk(pre_gap == T_RAS, "R7", "immediate miss pre spacing", pre_gap, T_RAS);
    chk(act_gap == T_RC, "R8", "immediate miss act spacing", act_gap, T_RC);

    send(1, 5, 0);
    drain();
    ovl_cnt = 0;
    send(0, 9, 200);
    send(1, 6, 24);
    drain();
    chk(ovl_cnt > 0, "R11", "activate during other burst", ovl_cnt, 1);

    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          int rows [4] = '{0, 16383, 0, 1};
          int cols [4] = '{0, 2047, 255, 2040};
          send(b, rows[r], cols[(r + b + c) % 4]);
        end
    drain();
    chk(q_rd == q_wr, "R12", "all requests served", q_rd, q_wr);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", q_rd, q_wr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule